// File: doc/BRIEF.md
# Mode-Banked Register File with Saved Status

This block is the register file of a processor core that runs in several privilege modes. It holds fifteen general registers and a program counter. The stack register (index 13) and the link register (index 14) have one private copy for each mode. The fast-interrupt mode also has its own copy of registers 8 to 12. Two combinational read ports and one clocked write port address the registers by a 4-bit index. Each port always sees the copies that belong to the current mode.

To change mode, the core gives a one-cycle mode-change strobe with the 5-bit code of the target mode. In that same clock edge the block:
- parks the live banked registers of the mode it is leaving;
- loads the copies that belong to the target mode;
- writes the supplied return address into the target mode's link register;
- copies the current status word into the target mode's saved-status register, when that mode has one.

The block shows the current mode code and that mode's saved-status word on two outputs. Exception vectoring and status-flag logic belong to the core around this block.

Top module: `bnk_regfile`

## Requirements
- R1: After reset, all sixteen registers, every banked copy and every saved-status register read zero, and the current mode is supervisor (code 0x13).
- R2: Register indices 0 to 14 select the general registers and index 15 selects the program counter. Both read ports return the selected live register combinationally. A write with `wr_en_i` high is visible on the read ports from the next clock edge.
- R3: The legal mode codes are user 0x10, fast-interrupt 0x11, interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. A change strobe with any other code changes no register, no saved status and not the current mode.
- R4: Registers 13 and 14 each have six copies: one for each of fast-interrupt, interrupt, supervisor, abort and undefined, and one copy that user and system modes share. On a legal change, register 13 takes the value it last held in the target mode's bank.
- R5: On a legal change, register 14 takes the value of `ret_addr_i`. The outgoing mode's register 14 is kept in its bank and comes back when that mode is entered again, unless the return address replaces it.
- R6: Registers 8 to 12 have a fast-interrupt copy and a copy shared by all other modes. They swap only when a change enters fast-interrupt mode from another mode, or leaves it for another mode.
- R7: Registers 0 to 7 and the program counter are not changed by a mode change.
- R8: A legal change to a mode other than user or system copies `status_i` into that mode's saved-status register. `saved_status_o` shows the current mode's saved status, and it reads zero in user and system modes.
- R9: A port write in the same cycle as a legal change goes to the target mode's copy of the register. A write to index 14 in that cycle overrides the return address.
- R10: A change to the mode already current leaves register 13 and registers 8 to 12 unchanged. It still loads the return address into register 14 and still saves the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_data_o | output | DATA_W | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_data_o | output | DATA_W | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write register index |
| wr_data_i | input | DATA_W | Write data |
| chg_valid_i | input | 1 | Mode-change strobe |
| chg_mode_i | input | 5 | Target mode code |
| status_i | input | DATA_W | Current status word to save |
| ret_addr_i | input | DATA_W | Return address for the new link register |
| cur_mode_o | output | 5 | Current mode code |
| saved_status_o | output | DATA_W | Saved status of the current mode |

## Verification
The assertions check on every cycle that:
- the mode follows a legal strobe and holds through an illegal one;
- the status word lands in the saved-status output of a mode that owns one;
- user and system modes show zero saved status;
- a port write shows up on a read port at the next edge;
- the return address reaches register 14 when no write competes.

Only the bench scenarios can show that a bank written in one mode comes back intact after round trips through the other modes. The same holds for the registers 8 to 12 swap, which happens only when fast-interrupt mode is entered or left. The bench also sweeps every 5-bit code and checks, through both read ports, that illegal codes change nothing.

// File: rtl/bnk_pkg.sv
package bnk_pkg;
    localparam int MODE_W    = 5;
    localparam int IDX_W     = 4;
    localparam int NUM_GPR   = 15;
    localparam int NUM_BANKS = 6;
    localparam int NUM_SPS   = NUM_BANKS - 1;
    localparam int FIQ_LO    = 8;
    localparam int FIQ_CNT   = 5;
    localparam int BIDX_W    = $clog2(NUM_BANKS);
    localparam int PC_IDX    = NUM_GPR;
    localparam int SP_IDX    = 13;
    localparam int LR_IDX    = 14;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'h10,
        MODE_FIQ = 5'h11,
        MODE_IRQ = 5'h12,
        MODE_SVC = 5'h13,
        MODE_ABT = 5'h17,
        MODE_UND = 5'h1B,
        MODE_SYS = 5'h1F
    } mode_e;

    localparam logic [BIDX_W-1:0] BANK_SHARED = 3'd0;
    localparam logic [BIDX_W-1:0] BANK_FIQ    = 3'd1;
    localparam logic [BIDX_W-1:0] BANK_IRQ    = 3'd2;
    localparam logic [BIDX_W-1:0] BANK_SVC    = 3'd3;
    localparam logic [BIDX_W-1:0] BANK_ABT    = 3'd4;
    localparam logic [BIDX_W-1:0] BANK_UND    = 3'd5;
endpackage

// File: rtl/bnk_mode_map.sv
module bnk_mode_map
    import bnk_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output logic              legal_o,
    output logic [BIDX_W-1:0] bank_o,
    output logic              has_sps_o,
    output logic              is_fiq_o
);
    always_comb begin
        legal_o = 1'b1;
        bank_o  = BANK_SHARED;
        case (mode_i)
            MODE_USR: bank_o = BANK_SHARED;
            MODE_SYS: bank_o = BANK_SHARED;
            MODE_FIQ: bank_o = BANK_FIQ;
            MODE_IRQ: bank_o = BANK_IRQ;
            MODE_SVC: bank_o = BANK_SVC;
            MODE_ABT: bank_o = BANK_ABT;
            MODE_UND: bank_o = BANK_UND;
            default: begin
                legal_o = 1'b0;
                bank_o  = BANK_SHARED;
            end
        endcase
        has_sps_o = legal_o && (bank_o != BANK_SHARED);
        is_fiq_o  = legal_o && (bank_o == BANK_FIQ);
    end
endmodule

// File: rtl/bnk_read_mux.sv
module bnk_read_mux
    import bnk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_i,
    input  logic [DATA_W-1:0]              pc_i,
    input  logic [IDX_W-1:0]               idx_i,
    output logic [DATA_W-1:0]              data_o
);
    always_comb begin
        if (idx_i == IDX_W'(PC_IDX)) data_o = pc_i;
        else                         data_o = gpr_i[idx_i];
    end
endmodule

// File: rtl/bnk_regfile.sv
module bnk_regfile
    import bnk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              chg_valid_i,
    input  logic [4:0]        chg_mode_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [DATA_W-1:0] ret_addr_i,
    output logic [4:0]        cur_mode_o,
    output logic [DATA_W-1:0] saved_status_o
);
    localparam int NUM_RD = 2;

    typedef struct packed {
        logic [MODE_W-1:0]                   mode;
        logic [NUM_GPR-1:0][DATA_W-1:0]      gpr;
        logic [DATA_W-1:0]                   pc;
        logic [NUM_BANKS-1:0][DATA_W-1:0]    sp_bank;
        logic [NUM_BANKS-1:0][DATA_W-1:0]    lr_bank;
        logic [FIQ_CNT-1:0][DATA_W-1:0]      hi_norm;
        logic [FIQ_CNT-1:0][DATA_W-1:0]      hi_fiq;
        logic [NUM_SPS-1:0][DATA_W-1:0]      sps;
    } rf_state_t;

    rf_state_t s_d, s_q;

    logic              cur_legal, cur_has_sps, cur_fiq;
    logic [BIDX_W-1:0] cur_bank;
    logic              new_legal, new_has_sps, new_fiq;
    logic [BIDX_W-1:0] new_bank;
    logic [BIDX_W-1:0] new_sps_idx, cur_sps_idx;
    logic              do_chg;

    bnk_mode_map u_cur_map (
        .mode_i    (s_q.mode),
        .legal_o   (cur_legal),
        .bank_o    (cur_bank),
        .has_sps_o (cur_has_sps),
        .is_fiq_o  (cur_fiq)
    );

    bnk_mode_map u_new_map (
        .mode_i    (chg_mode_i),
        .legal_o   (new_legal),
        .bank_o    (new_bank),
        .has_sps_o (new_has_sps),
        .is_fiq_o  (new_fiq)
    );

    assign do_chg      = chg_valid_i && new_legal;
    assign new_sps_idx = new_has_sps ? (new_bank - BIDX_W'(1)) : '0;
    assign cur_sps_idx = cur_has_sps ? (cur_bank - BIDX_W'(1)) : '0;

    // Next-state computation: bank swap first, then the port write
    always_comb begin
        s_d = s_q;
        if (do_chg) begin
            // park live stack/link of the outgoing mode
            s_d.sp_bank[cur_bank] = s_q.gpr[SP_IDX];
            s_d.lr_bank[cur_bank] = s_q.gpr[LR_IDX];
            if (cur_bank != new_bank) begin
                s_d.gpr[SP_IDX] = s_q.sp_bank[new_bank];
            end
            s_d.gpr[LR_IDX] = ret_addr_i;
            // high-register swap only across the fast-interrupt boundary
            if (new_fiq && !cur_fiq) begin
                for (int k = 0; k < FIQ_CNT; k++) begin
                    s_d.hi_norm[k]       = s_q.gpr[FIQ_LO + k];
                    s_d.gpr[FIQ_LO + k]  = s_q.hi_fiq[k];
                end
            end else if (cur_fiq && !new_fiq) begin
                for (int k = 0; k < FIQ_CNT; k++) begin
                    s_d.hi_fiq[k]        = s_q.gpr[FIQ_LO + k];
                    s_d.gpr[FIQ_LO + k]  = s_q.hi_norm[k];
                end
            end
            if (new_has_sps) begin
                s_d.sps[new_sps_idx] = status_i;
            end
            s_d.mode = chg_mode_i;
        end
        if (wr_en_i) begin
            if (wr_idx_i == IDX_W'(PC_IDX)) s_d.pc = wr_data_i;
            else                            s_d.gpr[wr_idx_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= MODE_SVC;
        end else begin
            s_q <= s_d;
        end
    end

    // Read ports
    logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx;
    logic [NUM_RD-1:0][DATA_W-1:0] rd_data;

    assign rd_idx[0]   = rd_a_idx_i;
    assign rd_idx[1]   = rd_b_idx_i;
    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        bnk_read_mux #(.DATA_W(DATA_W)) u_mux (
            .gpr_i  (s_q.gpr),
            .pc_i   (s_q.pc),
            .idx_i  (rd_idx[p]),
            .data_o (rd_data[p])
        );
    end

    assign cur_mode_o     = s_q.mode;
    assign saved_status_o = cur_has_sps ? s_q.sps[cur_sps_idx] : '0;
endmodule

// File: rtl/bnk_regfile_chk.sv
module bnk_regfile_chk
    import bnk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        rd_a_idx_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic [3:0]        rd_b_idx_i,
    input logic [DATA_W-1:0] rd_b_data_o,
    input logic              wr_en_i,
    input logic [3:0]        wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              chg_valid_i,
    input logic [4:0]        chg_mode_i,
    input logic [DATA_W-1:0] status_i,
    input logic [DATA_W-1:0] ret_addr_i,
    input logic [4:0]        cur_mode_o,
    input logic [DATA_W-1:0] saved_status_o
);
    function automatic logic legal_code(input logic [4:0] m);
        return (m == 5'h10) || (m == 5'h11) || (m == 5'h12) || (m == 5'h13) ||
               (m == 5'h17) || (m == 5'h1B) || (m == 5'h1F);
    endfunction

    function automatic logic shared_code(input logic [4:0] m);
        return (m == 5'h10) || (m == 5'h1F);
    endfunction

    // R3
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_valid_i && legal_code(chg_mode_i)) |=> (cur_mode_o == $past(chg_mode_i)));

    // R3
    bad_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_valid_i || !legal_code(chg_mode_i)) |=> $stable(cur_mode_o));

    // R8
    sps_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_valid_i && legal_code(chg_mode_i) && !shared_code(chg_mode_i))
        |=> (saved_status_o == $past(status_i)));

    // R8
    shared_no_sps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shared_code(cur_mode_o) |-> (saved_status_o == '0));

    // R2
    write_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((rd_a_idx_i != $past(wr_idx_i)) || (rd_a_data_o == $past(wr_data_i))));

    // R5
    lr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_valid_i && legal_code(chg_mode_i) && !(wr_en_i && wr_idx_i == 4'd14))
        |=> ((rd_b_idx_i != 4'd14) || (rd_b_data_o == $past(ret_addr_i))));
endmodule

bind bnk_regfile bnk_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_bnk_regfile.sv
module tb_bnk_regfile;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0, status = '0, ret_addr = '0;
    logic          wr_en = 1'b0, chg_valid = 1'b0;
    logic [4:0]    chg_mode = '0, cur_mode;
    logic [DW-1:0] saved_status;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    bnk_regfile #(.DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx_i(rd_a_idx), .rd_a_data_o(rd_a_data),
        .rd_b_idx_i(rd_b_idx), .rd_b_data_o(rd_b_data),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .chg_valid_i(chg_valid), .chg_mode_i(chg_mode),
        .status_i(status), .ret_addr_i(ret_addr),
        .cur_mode_o(cur_mode), .saved_status_o(saved_status)
    );

    // Reference model built from the requirements
    logic [DW-1:0] m_gpr [15];
    logic [DW-1:0] m_pc;
    logic [DW-1:0] m_sp [6];
    logic [DW-1:0] m_lr [6];
    logic [DW-1:0] m_hn [5];
    logic [DW-1:0] m_hf [5];
    logic [DW-1:0] m_sps [5];
    logic [4:0]    m_mode;

    function automatic int bank_of(input logic [4:0] m);
        case (m)
            5'h10, 5'h1F: return 0;
            5'h11: return 1;
            5'h12: return 2;
            5'h13: return 3;
            5'h17: return 4;
            5'h1B: return 5;
            default: return -1;
        endcase
    endfunction

    function automatic logic [DW-1:0] m_reg(input int i);
        return (i == 15) ? m_pc : m_gpr[i];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        int b;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_a_idx = 4'(i);
            rd_b_idx = 4'(15 - i);
            #1;
            check(tag, $sformatf("port A reg %0d", i), rd_a_data, m_reg(i));
            check(tag, $sformatf("port B reg %0d", 15 - i), rd_b_data, m_reg(15 - i));
        end
        check(tag, "mode", {27'd0, cur_mode}, {27'd0, m_mode});
        b = bank_of(m_mode);
        check(tag, "saved status", saved_status, (b > 0) ? m_sps[b-1] : '0);
    endtask

    task automatic apply(input logic cv, input logic [4:0] m, input logic [DW-1:0] st,
                         input logic [DW-1:0] ra, input logic we, input logic [3:0] wi,
                         input logic [DW-1:0] wd);
        int c, n;
        @(negedge clk);
        chg_valid = cv; chg_mode = m; status = st; ret_addr = ra;
        wr_en = we; wr_idx = wi; wr_data = wd;
        rd_a_idx = wi; rd_b_idx = 4'd14;
        @(posedge clk);
        #1;
        chg_valid = 1'b0; wr_en = 1'b0;
        c = bank_of(m_mode);
        n = bank_of(m);
        if (cv && n >= 0) begin
            m_sp[c] = m_gpr[13];
            m_lr[c] = m_gpr[14];
            m_gpr[13] = m_sp[n];
            m_gpr[14] = ra;
            if (n == 1 && c != 1) begin
                for (int k = 0; k < 5; k++) begin m_hn[k] = m_gpr[8+k]; m_gpr[8+k] = m_hf[k]; end
            end else if (c == 1 && n != 1) begin
                for (int k = 0; k < 5; k++) begin m_hf[k] = m_gpr[8+k]; m_gpr[8+k] = m_hn[k]; end
            end
            if (n > 0) m_sps[n-1] = st;
            m_mode = m;
        end
        if (we) begin
            if (wi == 4'd15) m_pc = wd;
            else m_gpr[wi] = wd;
        end
    endtask

    task automatic wr(input int i, input logic [DW-1:0] d);
        apply(1'b0, 5'h00, '0, '0, 1'b1, 4'(i), d);
    endtask

    task automatic chg(input logic [4:0] m, input logic [DW-1:0] st, input logic [DW-1:0] ra);
        apply(1'b1, m, st, ra, 1'b0, 4'd0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [4:0] modes [7];
        modes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F};
        for (int i = 0; i < 15; i++) m_gpr[i] = '0;
        for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; end
        for (int i = 0; i < 5; i++) begin m_hn[i] = '0; m_hf[i] = '0; m_sps[i] = '0; end
        m_pc = '0;
        m_mode = 5'h13;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R2: fill every index, including the program counter
        for (int i = 0; i < 16; i++) wr(i, 32'h1000_0000 | 32'(i * 32'h0101));
        check_all("R2");

        // R4 R5 R6 R7 R8: enter every mode, give it private values
        for (int k = 0; k < 7; k++) begin
            chg(modes[k], 32'h5A00_0000 + 32'(k), 32'hC000_0000 + 32'(k * 16));
            check_all("R4/R5/R6/R7/R8 forward");
            for (int i = 8; i < 14; i++) wr(i, 32'h2000_0000 | 32'(k << 8) | 32'(i));
        end
        // R4 R6: revisit in reverse order, banks must come back
        for (int k = 6; k >= 0; k--) begin
            chg(modes[k], 32'h6B00_0000 + 32'(k), 32'hD000_0000 + 32'(k * 16));
            check_all("R4/R6/R7 reverse");
        end

        // R3: sweep every 5-bit code
        for (int c = 0; c < 32; c++) begin
            chg(5'(c), 32'h7C00_0000 + 32'(c), 32'hE000_0000 + 32'(c));
            check_all("R3 code sweep");
        end

        // R10: change to the mode already current
        chg(5'h1F, 32'h0000_1111, 32'hAAAA_0001);
        check_all("R10 same shared");
        chg(5'h11, 32'h0000_2222, 32'hAAAA_0002);
        for (int i = 8; i < 14; i++) wr(i, 32'h3300_0000 | 32'(i));
        chg(5'h11, 32'h0000_3333, 32'hAAAA_0003);
        check_all("R10 same fiq");

        // R9: port write together with a change lands in the new mode
        apply(1'b1, 5'h12, 32'h0000_4444, 32'hBBBB_0001, 1'b1, 4'd14, 32'h9999_0014);
        check_all("R9 write lr on change");
        apply(1'b1, 5'h11, 32'h0000_5555, 32'hBBBB_0002, 1'b1, 4'd9, 32'h9999_0009);
        check_all("R9 write hi on change");
        apply(1'b1, 5'h10, 32'h0000_6666, 32'hBBBB_0003, 1'b1, 4'd13, 32'h9999_0013);
        check_all("R9 write sp on change");
        chg(5'h11, 32'h0000_7777, 32'hBBBB_0004);
        check_all("R9/R6 fiq bank kept write");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule